// File: doc/BRIEF.md
# Interconnect Test Pattern Generator

This block is a board-level pattern engine for interconnect testing through a boundary scan chain. Once configured over a small register write port, a start pulse makes it stream one stimulus bit per accepted transfer on a serial output with a valid/ready handshake. A chain of programmable length receives a whole vector, and the engine repeats this for as many vectors as the selected sequence needs. Each chain position is tagged by two mask bits as a control cell, a stimulus cell or a response cell. Control cells receive a fixed drive level. Stimulus cells receive the pattern. Response cells receive zero.

The pattern comes from one of four sequence classes: a 32-bit pseudo-random generator, a walking one or walking zero, a binary count (up or down) that never gives a net the all-zero or all-one code, and a constant level. An optional second pass repeats every vector with the stimulus bits inverted. The data returned by the chain at the same transfer is folded into a 32-bit multiple-input signature register, but only at response cell positions. When the last transfer completes, the engine raises a done flag and holds it. Driving the test clock and mode lines, and deciding whether the signature passes, are left to the surrounding logic.

Top module: `itp_gen`

## Requirements
- R1: After reset `tdiValid` and `done` are 0, `signature` is zero, and the engine waits for `start`.
- R2: A `start` pulse restarts the run on the next cycle, whether or not a run is active. It raises `tdiValid`, clears `done` and `signature`, and resets the cell, vector and pass indices. It also reloads the pseudo-random generator from the seed register, using 1 in place of a zero seed.
- R3: One chain cell is consumed per cycle with `tdiValid` and `tdiReady` both high. Cells go in order 0 to length-1 within a vector. While `tdiReady` is low, the current cell and `tdiBit` hold.
- R4: Mask encoding per cell: a control bit of 1 marks a control cell, which drives the configured control level. With a control bit of 0, a direction bit of 1 marks a stimulus cell and a direction bit of 0 marks a response cell, which drives 0.
- R5: Walk mode (sequence code 1) runs length vectors. In vector v, stimulus cell s carries 1 exactly when s equals v. Polarity 1 inverts this, giving a walking zero.
- R6: Count mode (sequence code 2) runs w vectors, where w is the smallest width with 2^w at least length+2. Vector v carries bit v (bit 0 first) of each cell's code. The code of cell s is s+1 with polarity 0 (up) and length-s with polarity 1 (down).
- R7: Constant mode (sequence code 3) runs one vector, and every stimulus cell carries the polarity bit.
- R8: Pseudo-random mode (sequence code 0) runs length vectors. A stimulus cell carries bit 31 of a 32-bit Galois shift register with polynomial x^32+x^22+x^2+x+1. The register advances once per accepted stimulus cell.
- R9: With the two-pass bit set, the whole vector set runs a second time with every stimulus bit inverted, which doubles the vector count.
- R10: On each accepted response cell, the signature shifts left one place, XORs 0x00400007 when its old bit 31 was 1, and XORs the returned bit `retBit` into bit 0. It is unchanged on every other cycle.
- R11: After the final transfer, `tdiValid` falls and `done` rises on the next cycle. `done` stays high, and the signature stays fixed, until the next `start`.
- R12: The register map is as follows. Address 0 holds the mode: bits 1:0 sequence, bit 2 polarity, bit 3 two-pass, bit 4 control level. Address 1 holds the length, where 0 counts as 1 and values above MAX_CELLS are clamped. Address 2 holds the seed. Addresses 4+j hold the control mask bits for cells 32j..32j+31, and addresses 8+j hold the direction mask bits for the same cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 32 | Register write data |
| start | input | 1 | Starts (or restarts) a run |
| tdiBit | output | 1 | Serial bit for the current chain cell |
| tdiValid | output | 1 | A run is active and `tdiBit` is offered |
| tdiReady | input | 1 | Consumer accepts the offered bit this cycle |
| retBit | input | 1 | Bit returned by the chain for the current cell |
| done | output | 1 | The last vector has been sent |
| signature | output | 32 | Signature of returned response bits |

## Verification
The bench builds the block with MAX_CELLS = 40, so the mask spans one full word and one partial word. At this size a length clamp above the top is observable, as is a full-length pseudo-random run with two passes. Count-mode widths of 2, 3, 4 and 6 vectors all fall within reach. Randomized ready stalls exercise holding mid-vector. Random mixes of control, stimulus and response cells exercise every cell role in every sequence class, and random returned data exercises the signature.

// File: rtl/itpg_pkg.sv
package itpg_pkg;

  typedef enum logic [1:0] {
    SEQ_PRBS  = 2'd0,
    SEQ_WALK  = 2'd1,
    SEQ_COUNT = 2'd2,
    SEQ_CONST = 2'd3
  } seqSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // run restart
    logic step;  // one cell accepted
  } strobe_t;

  localparam logic [31:0] FOLD_POLY = 32'h0040_0007;

  function automatic logic [31:0] lfsrNext(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? FOLD_POLY : 32'h0);
  endfunction

  function automatic logic [31:0] misrNext(input logic [31:0] s, input logic d);
    logic [31:0] n;
    n = lfsrNext(s);
    n[0] = n[0] ^ d;
    return n;
  endfunction

endpackage

// File: rtl/itpg_cfg.sv
module itpg_cfg #(
  parameter int MAX_CELLS = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [3:0]             wrAddr,
  input  logic [31:0]            wrData,
  output itpg_pkg::seqSel_e      seqSel,
  output logic                   polarity,
  output logic                   twoPass,
  output logic                   ctrlLevel,
  output logic [$clog2(MAX_CELLS+1)-1:0] vecLen,
  output logic [31:0]            seed,
  output logic [MAX_CELLS-1:0]   ctrlMask,
  output logic [MAX_CELLS-1:0]   dirMask
);
  localparam int SLOT_W     = $clog2(MAX_CELLS + 1);
  localparam int MASK_WORDS = (MAX_CELLS + 31) / 32;

  logic [31:0] ctrlWords [MASK_WORDS];
  logic [31:0] dirWords  [MASK_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqSel    <= itpg_pkg::SEQ_PRBS;
      polarity  <= 1'b0;
      twoPass   <= 1'b0;
      ctrlLevel <= 1'b0;
      vecLen    <= SLOT_W'(MAX_CELLS);
      seed      <= 32'd1;
      for (int j = 0; j < MASK_WORDS; j++) begin
        ctrlWords[j] <= '0;
        dirWords[j]  <= '0;
      end
    end else if (wrEn) begin
      case (wrAddr)
        4'd0: begin
          seqSel    <= itpg_pkg::seqSel_e'(wrData[1:0]);
          polarity  <= wrData[2];
          twoPass   <= wrData[3];
          ctrlLevel <= wrData[4];
        end
        4'd1: begin
          if (wrData == 32'd0)                 vecLen <= SLOT_W'(1);
          else if (wrData > 32'(MAX_CELLS))    vecLen <= SLOT_W'(MAX_CELLS);
          else                                 vecLen <= wrData[SLOT_W-1:0];
        end
        4'd2: seed <= wrData;
        default: begin
          for (int j = 0; j < MASK_WORDS; j++) begin
            if (wrAddr == 4'(4 + j)) ctrlWords[j] <= wrData;
            if (wrAddr == 4'(8 + j)) dirWords[j]  <= wrData;
          end
        end
      endcase
    end
  end

  always_comb begin
    for (int c = 0; c < MAX_CELLS; c++) begin
      ctrlMask[c] = ctrlWords[c / 32][c % 32];
      dirMask[c]  = dirWords[c / 32][c % 32];
    end
  end

endmodule

// File: rtl/itpg_ctrl.sv
module itpg_ctrl #(
  parameter int MAX_CELLS = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic                           tdiReady,
  input  itpg_pkg::seqSel_e              seqSel,
  input  logic                           twoPass,
  input  logic [$clog2(MAX_CELLS+1)-1:0] vecLen,
  output logic                           busy,
  output logic                           done,
  output itpg_pkg::strobe_t              strobe,
  output logic [$clog2(MAX_CELLS+1)-1:0] slot,
  output logic [$clog2(MAX_CELLS+1):0]   vec,
  output logic                           pass
);
  localparam int SLOT_W = $clog2(MAX_CELLS + 1);
  localparam int VEC_W  = SLOT_W + 1;

  // smallest w with 2^w >= n+2
  function automatic logic [VEC_W-1:0] codeWidth(input logic [SLOT_W-1:0] n);
    logic [VEC_W-1:0] w;
    w = VEC_W'(VEC_W);
    for (int i = VEC_W; i >= 1; i--)
      if ((32'd1 << i) >= (32'(n) + 32'd2)) w = VEC_W'(i);
    return w;
  endfunction

  logic [VEC_W-1:0] numVec;
  logic step, lastSlot, lastVec, lastPass;

  always_comb begin
    case (seqSel)
      itpg_pkg::SEQ_COUNT: numVec = codeWidth(vecLen);
      itpg_pkg::SEQ_CONST: numVec = VEC_W'(1);
      default:             numVec = VEC_W'(vecLen);
    endcase
  end

  assign step     = busy && tdiReady;
  assign lastSlot = (slot == vecLen - 1'b1);
  assign lastVec  = (vec == numVec - 1'b1);
  assign lastPass = !twoPass || pass;
  assign strobe   = '{load: start, step: step};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; done <= 1'b0; slot <= '0; vec <= '0; pass <= 1'b0;
    end else if (start) begin
      busy <= 1'b1; done <= 1'b0; slot <= '0; vec <= '0; pass <= 1'b0;
    end else if (step) begin
      if (!lastSlot) begin
        slot <= slot + 1'b1;
      end else begin
        slot <= '0;
        if (!lastVec) begin
          vec <= vec + 1'b1;
        end else begin
          vec <= '0;
          if (lastPass) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            pass <= 1'b1;
          end
        end
      end
    end
  end

  p_slot_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (slot < vecLen));
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && !done && slot == '0 && vec == '0 && !pass));
  p_done_after_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(step));
  p_valid_done_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

endmodule

// File: rtl/itpg_dp.sv
module itpg_dp #(
  parameter int MAX_CELLS = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  itpg_pkg::strobe_t              strobe,
  input  logic                           busy,
  input  logic [$clog2(MAX_CELLS+1)-1:0] slot,
  input  logic [$clog2(MAX_CELLS+1):0]   vec,
  input  logic                           pass,
  input  itpg_pkg::seqSel_e              seqSel,
  input  logic                           polarity,
  input  logic                           ctrlLevel,
  input  logic [$clog2(MAX_CELLS+1)-1:0] vecLen,
  input  logic [31:0]                    seed,
  input  logic [MAX_CELLS-1:0]           ctrlMask,
  input  logic [MAX_CELLS-1:0]           dirMask,
  input  logic                           retBit,
  output logic                           tdiBit,
  output logic [31:0]                    signature
);
  localparam int SLOT_W = $clog2(MAX_CELLS + 1);
  localparam int PAD    = 1 << SLOT_W;

  logic [PAD-1:0]    ctrlPad, dirPad;
  logic [31:0]       lfsr;
  logic [SLOT_W:0]   code, codeShift;
  logic              isCtrl, isStim, isResp, patBit, stimBit;

  assign ctrlPad = PAD'(ctrlMask);
  assign dirPad  = PAD'(dirMask);
  assign isCtrl  = ctrlPad[slot];
  assign isStim  = !isCtrl && dirPad[slot];
  assign isResp  = !isCtrl && !dirPad[slot];

  assign code      = polarity ? ({1'b0, vecLen} - {1'b0, slot}) : ({1'b0, slot} + 1'b1);
  assign codeShift = code >> vec;

  always_comb begin
    case (seqSel)
      itpg_pkg::SEQ_PRBS:  patBit = lfsr[31];
      itpg_pkg::SEQ_WALK:  patBit = ((SLOT_W+1)'(slot) == vec) ^ polarity;
      itpg_pkg::SEQ_COUNT: patBit = codeShift[0];
      default:             patBit = polarity;
    endcase
    stimBit = patBit ^ pass;
    if (!busy)       tdiBit = 1'b0;
    else if (isCtrl) tdiBit = ctrlLevel;
    else if (isStim) tdiBit = stimBit;
    else             tdiBit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr      <= 32'd1;
      signature <= '0;
    end else if (strobe.load) begin
      lfsr      <= (seed == 32'd0) ? 32'd1 : seed;
      signature <= '0;
    end else if (strobe.step) begin
      if (isStim) lfsr      <= itpg_pkg::lfsrNext(lfsr);
      if (isResp) signature <= itpg_pkg::misrNext(signature, retBit);
    end
  end

  p_sig_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.load) |=> $stable(signature));
  p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (lfsr != 32'd0));
  p_resp_drives_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isResp) |-> !tdiBit);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tdiBit);

endmodule

// File: rtl/itp_gen.sv
module itp_gen #(
  parameter int MAX_CELLS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        start,
  output logic        tdiBit,
  output logic        tdiValid,
  input  logic        tdiReady,
  input  logic        retBit,
  output logic        done,
  output logic [31:0] signature
);
  localparam int SLOT_W = $clog2(MAX_CELLS + 1);

  itpg_pkg::seqSel_e   seqSel;
  itpg_pkg::strobe_t   strobe;
  logic                polarity, twoPass, ctrlLevel, pass;
  logic [SLOT_W-1:0]   vecLen, slot;
  logic [SLOT_W:0]     vec;
  logic [31:0]         seed;
  logic [MAX_CELLS-1:0] ctrlMask, dirMask;

  itpg_cfg #(.MAX_CELLS(MAX_CELLS)) u_cfg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .seqSel(seqSel), .polarity(polarity), .twoPass(twoPass), .ctrlLevel(ctrlLevel),
    .vecLen(vecLen), .seed(seed), .ctrlMask(ctrlMask), .dirMask(dirMask)
  );

  itpg_ctrl #(.MAX_CELLS(MAX_CELLS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .tdiReady(tdiReady),
    .seqSel(seqSel), .twoPass(twoPass), .vecLen(vecLen),
    .busy(tdiValid), .done(done), .strobe(strobe),
    .slot(slot), .vec(vec), .pass(pass)
  );

  itpg_dp #(.MAX_CELLS(MAX_CELLS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(tdiValid),
    .slot(slot), .vec(vec), .pass(pass),
    .seqSel(seqSel), .polarity(polarity), .ctrlLevel(ctrlLevel),
    .vecLen(vecLen), .seed(seed), .ctrlMask(ctrlMask), .dirMask(dirMask),
    .retBit(retBit), .tdiBit(tdiBit), .signature(signature)
  );

endmodule

// File: tb/itp_gen_tb.sv
module itp_gen_tb;
  localparam int NC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic start = 1'b0;
  logic tdiReady = 1'b0;
  logic retBit = 1'b0;
  logic tdiBit, tdiValid, done;
  logic [31:0] signature;

  int checks = 0;
  int failures = 0;
  bit [NC-1:0] mCtrl, mDir;

  always #5 clk = ~clk;

  itp_gen #(.MAX_CELLS(NC)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .start(start), .tdiBit(tdiBit), .tdiValid(tdiValid), .tdiReady(tdiReady),
    .retBit(retBit), .done(done), .signature(signature)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] stepPoly(bit [31:0] s);
    bit [31:0] t = {s[30:0], 1'b0};
    if (s[31]) t = t ^ ((32'd1 << 22) | (32'd1 << 2) | (32'd1 << 1) | 32'd1);
    return t;
  endfunction

  function automatic int widthFor(int n);
    for (int w = 1; w < 31; w++) if ((1 << w) >= n + 2) return w;
    return 31;
  endfunction

  task automatic regWrite(int a, bit [31:0] d);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runCase(string name, int mode, bit pol, bit two, bit lvl,
                         int lenReq, bit [31:0] seedReq);
    int len, nv, s, v, p, code;
    bit [31:0] lf, sg;
    bit rdy, rb, eb, fin;
    string tag;
    len = (lenReq == 0) ? 1 : (lenReq > NC ? NC : lenReq);
    nv  = (mode == 2) ? widthFor(len) : (mode == 3 ? 1 : len);
    regWrite(0, {27'd0, lvl, two, pol, 2'(mode)});
    regWrite(1, 32'(lenReq));
    regWrite(2, seedReq);
    regWrite(4, mCtrl[31:0]);  regWrite(5, {24'd0, mCtrl[NC-1:32]});
    regWrite(8, mDir[31:0]);   regWrite(9, {24'd0, mDir[NC-1:32]});
    start = 1'b1; @(posedge clk); @(negedge clk); start = 1'b0;
    #1;
    check(tdiValid == 1'b1 && done == 1'b0, {"R2 start ", name}, {tdiValid, done}, 2'b10);
    check(signature == 32'd0, {"R2 sig clear ", name}, signature, 0);
    s = 0; v = 0; p = 0; lf = (seedReq == 0) ? 32'd1 : seedReq; sg = '0; fin = 0;
    while (!fin) begin
      rdy = ($urandom % 10) < 7;
      rb  = 1'($urandom);
      tdiReady = rdy; retBit = rb;
      #1;
      if (mCtrl[s])      begin eb = lvl; tag = "R4 ctrl"; end
      else if (!mDir[s]) begin eb = 0;   tag = "R4 resp"; end
      else begin
        case (mode)
          0: begin eb = lf[31]; tag = "R8 prbs"; end
          1: begin eb = (s == v) ^ pol; tag = "R5 walk"; end
          2: begin code = pol ? len - s : s + 1; eb = 1'((code >> v) & 1); tag = "R6 count"; end
          default: begin eb = pol; tag = "R7 const"; end
        endcase
        eb = eb ^ 1'(p);
        if (p != 0) tag = {tag, " R9 pass2"};
      end
      check(tdiValid == 1'b1, {"R3 valid ", name}, tdiValid, 1);
      check(tdiBit == eb, {tag, " ", name}, tdiBit, eb);
      @(posedge clk);
      if (rdy) begin
        if (!mCtrl[s] && !mDir[s]) sg = stepPoly(sg) ^ 32'(rb);
        if (!mCtrl[s] && mDir[s])  lf = stepPoly(lf);
        s++;
        if (s == len) begin
          s = 0; v++;
          if (v == nv) begin
            v = 0;
            if (two && p == 0) p = 1; else fin = 1;
          end
        end
      end
      @(negedge clk);
    end
    tdiReady = 1'b0;
    #1;
    check(done == 1'b1 && tdiValid == 1'b0, {"R11 end ", name}, {done, tdiValid}, 2'b10);
    check(signature == sg, {"R10 signature ", name}, signature, sg);
    tdiReady = 1'b1; retBit = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(done == 1'b1 && tdiValid == 1'b0 && signature == sg,
          {"R11 hold ", name}, signature, sg);
    tdiReady = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(tdiValid == 0 && done == 0, "R1 reset flags", {tdiValid, done}, 0);
    check(signature == 0, "R1 reset signature", signature, 0);

    // directed: all stimulus cells
    mCtrl = '0; mDir = '1;
    runCase("walk1", 1, 0, 0, 0, 5, 0);
    runCase("walk0 two-pass", 1, 1, 1, 0, 7, 0);
    runCase("count up len6", 2, 0, 0, 0, 6, 0);
    runCase("count down len14", 2, 1, 1, 0, 14, 0);
    runCase("count len2", 2, 0, 0, 0, 2, 0);
    runCase("const one two-pass", 3, 1, 1, 0, 9, 0);
    runCase("prbs seed0 R12 len0", 0, 0, 0, 0, 0, 0);
    runCase("prbs full two-pass", 0, 0, 1, 0, NC, 32'hDEAD_BEEF);
    runCase("count R12 clamp", 2, 0, 0, 0, 100, 0);
    // directed: mixed roles
    mCtrl = 40'h00_0000_0101; mDir = 40'hF0_F0F0_F0F0;
    runCase("mixed walk", 1, 0, 0, 1, 12, 0);
    mCtrl = '0; mDir = '0;
    runCase("all response const", 3, 0, 0, 0, NC, 0);
    // constrained random
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < NC; c++) begin
        mCtrl[c] = ($urandom % 8) == 0;
        mDir[c]  = 1'($urandom);
      end
      runCase($sformatf("rand%0d", k), int'($urandom % 4), 1'($urandom), 1'($urandom),
              1'($urandom), 1 + int'($urandom % NC), $urandom);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule